// File: doc/BRIEF.md
# Flash Command Port with Single-Entry Hold Stage

This block sits between firmware and a set of flash banks on one channel. Firmware fills a group of command registers over a simple register bus. Those registers hold the opcode, the target bank, option flags, the transfer address and length, the column, the destination column and row, and a low and a high row half kept separately for each bank. A write of any value to the launch register takes a snapshot of all of that into a one-entry hold stage. The snapshot carries the row halves of the bank named by the target register.

The hold stage keeps the snapshot until the target bank can take it. Each bank is modelled as a countdown timer that is idle at zero. It loads a latency picked by the opcode when it accepts a command, and it stays busy until the count runs out. Banks share the hold stage, but their busy periods may overlap, so the channel can interleave work across banks. Firmware polls a status register to learn when the hold stage has drained, and it can read each bank's busy bit. An accepted command appears for one cycle on the accept outputs.

Top module: `flash_cmd_port`

## Requirements
- R1: After a synchronous reset, all of the following read 0: the hold-stage status register (address 9), the hold target register (address 10), every bank status register (address 48+b) and every command register.
- R2: Command registers read back what was written, truncated to their field widths. The opcode at address 0 keeps 8 bits. The target at address 1 keeps log2(NUM_BANKS) bits. The low and high row halves are at 16+b and 32+b and keep 16 bits each.
- R3: A write of any data value to the launch address (8) while the hold stage is empty fills it. Status bit 0 reads 1 in the cycle after the write.
- R4: While the hold stage is full, address 10 returns the target bank captured at launch.
- R5: When the held command's target bank is idle, acc_valid is high for that cycle. The accept outputs show the snapshot, and acc_row is {row high, row low} of the target bank. Status bit 0 reads 0 in the next cycle. At most one bank accepts per cycle.
- R6: An accepting bank reads busy (bit 0 of address 48+b, and bank_busy[b]) for exactly a fixed number of cycles, and then reads idle. That number is LAT_READ for opcode 0x01, LAT_PROG for 0x02, LAT_ERASE for 0x03 and LAT_MISC for any other opcode.
- R7: A command whose target bank is busy stays in the hold stage with acc_valid low. It is accepted in the first cycle that the bank reads idle.
- R8: A command for an idle bank is accepted while other banks are still busy, so busy periods of different banks overlap.
- R9: A launch while the hold stage is full is dropped, and the held contents stay unchanged. It sets status bit 1, which stays set until reset.
- R10: Writes to the command registers after a launch do not change the held snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Combinational read data |
| acc_valid | output | 1 | Held command accepted by its bank this cycle |
| acc_bank | output | 4 | Accepted target bank |
| acc_opcode | output | 8 | Accepted opcode |
| acc_flags | output | 8 | Accepted option flags |
| acc_xaddr | output | 32 | Accepted transfer address |
| acc_xlen | output | 16 | Accepted transfer length |
| acc_col | output | 16 | Accepted column |
| acc_row | output | 32 | Accepted row, high half over low half |
| acc_dcol | output | 16 | Accepted destination column |
| acc_drow | output | 32 | Accepted destination row |
| bank_busy | output | NUM_BANKS | Per-bank busy bits |

## Verification
The bench aims at three kinds of timing error. A design that accepted into a busy bank, or accepted one cycle late after the bank went idle, would show acc_valid in the wrong cycle of the held-command test. A design that let a second launch overwrite the hold stage, or that captured live registers at accept time rather than at launch, would show the wrong opcode or target at accept. A bank timer that is off by one would give a busy count that differs from the latency of that opcode, for each of the four opcode classes.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int OP_W    = 8;
    localparam int FLAG_W  = 8;
    localparam int XLEN_W  = 16;
    localparam int COL_W   = 16;
    localparam int ROWH_W  = 16;
    localparam int BANK_FW = 4;   // room for up to 16 banks

    // register addresses
    localparam logic [ADDR_W-1:0] A_OPCODE = 6'd0;
    localparam logic [ADDR_W-1:0] A_TARGET = 6'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 6'd2;
    localparam logic [ADDR_W-1:0] A_XADDR  = 6'd3;
    localparam logic [ADDR_W-1:0] A_XLEN   = 6'd4;
    localparam logic [ADDR_W-1:0] A_COL    = 6'd5;
    localparam logic [ADDR_W-1:0] A_DCOL   = 6'd6;
    localparam logic [ADDR_W-1:0] A_DROW   = 6'd7;
    localparam logic [ADDR_W-1:0] A_LAUNCH = 6'd8;
    localparam logic [ADDR_W-1:0] A_HSTAT  = 6'd9;
    localparam logic [ADDR_W-1:0] A_HTGT   = 6'd10;
    // banked windows, selected by address bits [5:4]
    localparam logic [1:0] WIN_ROW_LO = 2'b01;
    localparam logic [1:0] WIN_ROW_HI = 2'b10;
    localparam logic [1:0] WIN_BSTAT  = 2'b11;

    localparam logic [OP_W-1:0] OP_READ  = 8'h01;
    localparam logic [OP_W-1:0] OP_PROG  = 8'h02;
    localparam logic [OP_W-1:0] OP_ERASE = 8'h03;

    typedef enum logic [1:0] {
        LK_READ,
        LK_PROG,
        LK_ERASE,
        LK_MISC
    } lat_kind_e;

    typedef struct packed {
        logic [OP_W-1:0]     opcode;
        logic [BANK_FW-1:0]  bank;
        logic [FLAG_W-1:0]   flags;
        logic [DATA_W-1:0]   xaddr;
        logic [XLEN_W-1:0]   xlen;
        logic [COL_W-1:0]    col;
        logic [2*ROWH_W-1:0] row;
        logic [COL_W-1:0]    dcol;
        logic [DATA_W-1:0]   drow;
    } cmd_t;

    function automatic lat_kind_e kind_of(input logic [OP_W-1:0] op);
        case (op)
            OP_READ:  return LK_READ;
            OP_PROG:  return LK_PROG;
            OP_ERASE: return LK_ERASE;
            default:  return LK_MISC;
        endcase
    endfunction
endpackage

// File: rtl/fcp_regs.sv
module fcp_regs
    import fcp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit,
    output cmd_t              port_cmd,
    output logic              launch
);
    logic [OP_W-1:0]   opcode_q;
    logic [BANK_W-1:0] target_q;
    logic [FLAG_W-1:0] flags_q;
    logic [DATA_W-1:0] xaddr_q;
    logic [XLEN_W-1:0] xlen_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  dcol_q;
    logic [DATA_W-1:0] drow_q;
    logic [ROWH_W-1:0] row_lo_q [NUM_BANKS];
    logic [ROWH_W-1:0] row_hi_q [NUM_BANKS];

    logic wr_bank_ok;
    logic rd_bank_ok;
    assign wr_bank_ok = int'(wr_addr[3:0]) < NUM_BANKS;
    assign rd_bank_ok = int'(rd_addr[3:0]) < NUM_BANKS;

    assign launch = wr_en && (wr_addr == A_LAUNCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_q <= '0;
            target_q <= '0;
            flags_q  <= '0;
            xaddr_q  <= '0;
            xlen_q   <= '0;
            col_q    <= '0;
            dcol_q   <= '0;
            drow_q   <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                row_lo_q[b] <= '0;
                row_hi_q[b] <= '0;
            end
        end else if (wr_en) begin
            case (wr_addr)
                A_OPCODE: opcode_q <= wr_data[OP_W-1:0];
                A_TARGET: target_q <= wr_data[BANK_W-1:0];
                A_FLAGS:  flags_q  <= wr_data[FLAG_W-1:0];
                A_XADDR:  xaddr_q  <= wr_data;
                A_XLEN:   xlen_q   <= wr_data[XLEN_W-1:0];
                A_COL:    col_q    <= wr_data[COL_W-1:0];
                A_DCOL:   dcol_q   <= wr_data[COL_W-1:0];
                A_DROW:   drow_q   <= wr_data;
                default: begin
                    if (wr_bank_ok && wr_addr[5:4] == WIN_ROW_LO)
                        row_lo_q[wr_addr[BANK_W-1:0]] <= wr_data[ROWH_W-1:0];
                    if (wr_bank_ok && wr_addr[5:4] == WIN_ROW_HI)
                        row_hi_q[wr_addr[BANK_W-1:0]] <= wr_data[ROWH_W-1:0];
                end
            endcase
        end
    end

    always_comb begin
        port_cmd        = '0;
        port_cmd.opcode = opcode_q;
        port_cmd.bank   = BANK_FW'(target_q);
        port_cmd.flags  = flags_q;
        port_cmd.xaddr  = xaddr_q;
        port_cmd.xlen   = xlen_q;
        port_cmd.col    = col_q;
        port_cmd.row    = {row_hi_q[target_q], row_lo_q[target_q]};
        port_cmd.dcol   = dcol_q;
        port_cmd.drow   = drow_q;
    end

    always_comb begin
        rd_hit  = 1'b1;
        rd_data = '0;
        case (rd_addr)
            A_OPCODE: rd_data = DATA_W'(opcode_q);
            A_TARGET: rd_data = DATA_W'(target_q);
            A_FLAGS:  rd_data = DATA_W'(flags_q);
            A_XADDR:  rd_data = xaddr_q;
            A_XLEN:   rd_data = DATA_W'(xlen_q);
            A_COL:    rd_data = DATA_W'(col_q);
            A_DCOL:   rd_data = DATA_W'(dcol_q);
            A_DROW:   rd_data = drow_q;
            default: begin
                if (rd_bank_ok && rd_addr[5:4] == WIN_ROW_LO)
                    rd_data = DATA_W'(row_lo_q[rd_addr[BANK_W-1:0]]);
                else if (rd_bank_ok && rd_addr[5:4] == WIN_ROW_HI)
                    rd_data = DATA_W'(row_hi_q[rd_addr[BANK_W-1:0]]);
                else
                    rd_hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fcp_hold.sv
module fcp_hold
    import fcp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  cmd_t port_cmd,
    input  logic accept,
    output logic full,
    output logic ovr,
    output cmd_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ovr  <= 1'b0;
            held <= '0;
        end else begin
            if (launch && full)
                ovr <= 1'b1;
            if (launch && !full) begin
                full <= 1'b1;
                held <= port_cmd;
            end else if (accept) begin
                full <= 1'b0;
            end
        end
    end

    assert_launch_fills_R3: assert property (@(posedge clk) disable iff (rst)
        (launch && !full) |=> (full && held == $past(port_cmd)));
    assert_accept_needs_entry_R5: assert property (@(posedge clk) disable iff (rst)
        accept |-> full);
    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> !full);
    assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (launch && full && !accept) |=> (full && $stable(held)));
    assert_drop_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (launch && full) |=> ovr);
    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);
endmodule

// File: rtl/fcp_bank.sv
module fcp_bank
    import fcp_pkg::*;
#(
    parameter int LAT_READ  = 4,
    parameter int LAT_PROG  = 9,
    parameter int LAT_ERASE = 15,
    parameter int LAT_MISC  = 2,
    localparam int LAT_MAX = (LAT_ERASE > LAT_PROG ? LAT_ERASE : LAT_PROG) > LAT_READ ?
                             (LAT_ERASE > LAT_PROG ? LAT_ERASE : LAT_PROG) :
                             (LAT_READ > LAT_MISC ? LAT_READ : LAT_MISC),
    localparam int CNT_W = $clog2(LAT_MAX + 1) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] opcode,
    output logic            busy
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lat;

    always_comb begin
        case (kind_of(opcode))
            LK_READ:  lat = CNT_W'(LAT_READ);
            LK_PROG:  lat = CNT_W'(LAT_PROG);
            LK_ERASE: lat = CNT_W'(LAT_ERASE);
            default:  lat = CNT_W'(LAT_MISC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= lat;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_start_idle_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    assert_stay_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/flash_cmd_port.sv
module flash_cmd_port
    import fcp_pkg::*;
#(
    parameter int NUM_BANKS = 4,   // power of two, 2..16
    parameter int LAT_READ  = 4,
    parameter int LAT_PROG  = 9,
    parameter int LAT_ERASE = 15,
    parameter int LAT_MISC  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [5:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [5:0]           rd_addr,
    output logic [31:0]          rd_data,
    output logic                 acc_valid,
    output logic [3:0]           acc_bank,
    output logic [7:0]           acc_opcode,
    output logic [7:0]           acc_flags,
    output logic [31:0]          acc_xaddr,
    output logic [15:0]          acc_xlen,
    output logic [15:0]          acc_col,
    output logic [31:0]          acc_row,
    output logic [15:0]          acc_dcol,
    output logic [31:0]          acc_drow,
    output logic [NUM_BANKS-1:0] bank_busy
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    logic              launch;
    logic              full;
    logic              ovr;
    logic              reg_hit;
    logic [DATA_W-1:0] reg_rd;
    cmd_t              port_cmd;
    cmd_t              held;
    logic [NUM_BANKS-1:0] start;
    logic              accept;

    fcp_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(reg_rd), .rd_hit(reg_hit),
        .port_cmd(port_cmd), .launch(launch)
    );

    fcp_hold u_hold (
        .clk(clk), .rst(rst),
        .launch(launch), .port_cmd(port_cmd), .accept(accept),
        .full(full), .ovr(ovr), .held(held)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign start[b] = full && (held.bank == BANK_FW'(b)) && !bank_busy[b];
        fcp_bank #(
            .LAT_READ(LAT_READ), .LAT_PROG(LAT_PROG),
            .LAT_ERASE(LAT_ERASE), .LAT_MISC(LAT_MISC)
        ) u_bank (
            .clk(clk), .rst(rst),
            .start(start[b]), .opcode(held.opcode),
            .busy(bank_busy[b])
        );
    end

    assign accept     = |start;
    assign acc_valid  = accept;
    assign acc_bank   = held.bank;
    assign acc_opcode = held.opcode;
    assign acc_flags  = held.flags;
    assign acc_xaddr  = held.xaddr;
    assign acc_xlen   = held.xlen;
    assign acc_col    = held.col;
    assign acc_row    = held.row;
    assign acc_dcol   = held.dcol;
    assign acc_drow   = held.drow;

    always_comb begin
        rd_data = '0;
        if (reg_hit)
            rd_data = reg_rd;
        else if (rd_addr == A_HSTAT)
            rd_data = {30'd0, ovr, full};
        else if (rd_addr == A_HTGT)
            rd_data = DATA_W'(held.bank);
        else if (rd_addr[5:4] == WIN_BSTAT && int'(rd_addr[3:0]) < NUM_BANKS)
            rd_data = DATA_W'(bank_busy[rd_addr[BANK_W-1:0]]);
    end

    assert_one_accept_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start));
    assert_accept_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !launch) |=> !accept);
endmodule

// File: tb/flash_cmd_port_tb.sv
module flash_cmd_port_tb;
    import fcp_pkg::*;

    localparam int NB = 4;
    localparam int L_RD = 4, L_PG = 9, L_ER = 15, L_MS = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data;
    logic [5:0]  rd_addr;
    logic [31:0] rd_data;
    logic        acc_valid;
    logic [3:0]  acc_bank;
    logic [7:0]  acc_opcode, acc_flags;
    logic [31:0] acc_xaddr, acc_row, acc_drow;
    logic [15:0] acc_xlen, acc_col, acc_dcol;
    logic [NB-1:0] bank_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_cmd_port #(.NUM_BANKS(NB), .LAT_READ(L_RD), .LAT_PROG(L_PG),
                     .LAT_ERASE(L_ER), .LAT_MISC(L_MS)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .acc_valid(acc_valid),
        .acc_bank(acc_bank), .acc_opcode(acc_opcode), .acc_flags(acc_flags),
        .acc_xaddr(acc_xaddr), .acc_xlen(acc_xlen), .acc_col(acc_col),
        .acc_row(acc_row), .acc_dcol(acc_dcol), .acc_drow(acc_drow),
        .bank_busy(bank_busy)
    );

    // {opcode, bank, row low, expected busy cycles}
    localparam logic [35:0] VEC [6] = '{
        {8'h01, 4'd0, 16'h1111, 8'd4},
        {8'h02, 4'd1, 16'h2222, 8'd9},
        {8'h03, 4'd2, 16'h3333, 8'd15},
        {8'h7E, 4'd3, 16'h4444, 8'd2},
        {8'h02, 4'd3, 16'h5555, 8'd9},
        {8'h00, 4'd0, 16'h6666, 8'd2}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic busy_count(input int b, output int n);
        logic [31:0] v;
        n = 0;
        rd(6'h30 + 6'(b), v);
        while (v[0] && n < 100) begin
            n++;
            tick();
            rd(6'h30 + 6'(b), v);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(A_HSTAT, v);  chk("R1 hold status", v, 0);
        rd(A_HTGT, v);   chk("R1 hold target", v, 0);
        rd(A_OPCODE, v); chk("R1 opcode reg", v, 0);
        for (int b = 0; b < NB; b++) begin
            rd(6'h30 + 6'(b), v); chk("R1 bank status", v, 0);
        end

        // R2 field widths
        wr(A_OPCODE, 32'h1AB); rd(A_OPCODE, v); chk("R2 opcode width", v, 32'hAB);
        wr(A_TARGET, 32'h7);   rd(A_TARGET, v); chk("R2 target width", v, 3);
        wr(6'h12, 32'hFFFF_1234); rd(6'h12, v); chk("R2 row low width", v, 32'h1234);
        for (int b = 0; b < NB; b++) wr(6'h20 + 6'(b), 32'hA000 + 32'(b));
        rd(6'h22, v); chk("R2 row high", v, 32'hA002);

        // table walk: R3 R4 R5 R6
        foreach (VEC[i]) begin
            logic [7:0]  op;  logic [3:0] bk;
            logic [15:0] rl;  logic [7:0] lat;
            {op, bk, rl, lat} = VEC[i];
            wr(A_OPCODE, 32'(op));
            wr(A_TARGET, 32'(bk));
            wr(6'h10 + 6'(bk), 32'(rl));
            wr(A_LAUNCH, (i % 2 == 0) ? 32'hDEAD_BEEF : 32'h0);
            rd(A_HSTAT, v);  chk("R3 full after launch", v, 1);
            rd(A_HTGT, v);   chk("R4 hold target", v, 32'(bk));
            chk("R5 acc_valid", 32'(acc_valid), 1);
            chk("R5 acc_opcode", 32'(acc_opcode), 32'(op));
            chk("R5 acc_bank", 32'(acc_bank), 32'(bk));
            chk("R5 acc_row", acc_row, {16'hA000 + 16'(bk), rl});
            tick();
            rd(A_HSTAT, v);  chk("R5 cleared after accept", v, 0);
            busy_count(int'(bk), n);
            chk("R6 busy cycles", 32'(n), 32'(lat));
        end

        // R7 held while target busy
        wr(A_TARGET, 0); wr(A_OPCODE, 32'(OP_ERASE)); wr(A_LAUNCH, 1);
        tick();
        wr(A_OPCODE, 32'(OP_READ)); wr(A_LAUNCH, 1);
        chk("R7 no accept while busy", 32'(acc_valid), 0);
        rd(6'h30, v);
        while (v[0]) begin
            rd(A_HSTAT, v); chk("R7 still held", v, 1);
            tick(); rd(6'h30, v);
        end
        chk("R7 accept when idle", 32'(acc_valid), 1);
        chk("R7 accepted opcode", 32'(acc_opcode), 32'(OP_READ));
        tick();
        rd(A_HSTAT, v); chk("R7 drained", v, 0);
        rd(6'h30, v);   chk("R7 bank busy again", v, 1);
        repeat (20) tick();

        // R8 overlap of banks
        wr(A_TARGET, 1); wr(A_OPCODE, 32'(OP_ERASE)); wr(A_LAUNCH, 1);
        tick();
        wr(A_TARGET, 2); wr(A_LAUNCH, 1);
        chk("R8 accept beside busy bank", 32'(acc_valid), 1);
        tick();
        chk("R8 both busy", 32'(bank_busy), 32'b0110);
        repeat (20) tick();

        // R9 and R10: drop while full, snapshot kept
        wr(A_TARGET, 3); wr(A_OPCODE, 32'(OP_ERASE)); wr(A_LAUNCH, 1);
        tick();
        wr(A_OPCODE, 32'(OP_PROG)); wr(A_LAUNCH, 1);
        wr(A_OPCODE, 32'h55); wr(A_TARGET, 2); wr(A_LAUNCH, 1);
        rd(A_HSTAT, v); chk("R9 overrun and full", v, 3);
        rd(A_HTGT, v);  chk("R9 target unchanged", v, 3);
        n = 0;
        while (!acc_valid && n < 100) begin n++; tick(); end
        chk("R10 snapshot opcode", 32'(acc_opcode), 32'(OP_PROG));
        chk("R9 dropped launch lost", 32'(acc_bank), 3);
        tick();
        rd(A_HSTAT, v); chk("R9 overrun sticky", v, 2);
        chk("R9 dropped bank untouched", 32'(bank_busy[2]), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule